// File: doc/BRIEF.md
# Pattern Memory Playback Sequencer

This block replays a stored test vector from a pattern memory onto a streaming output port, for example to feed a DAC. The pattern memory is organised in 256-bit words. All offsets, lengths and addresses are counted in those words. The memory itself lives outside the block. The sequencer drives a read enable and a word address, and the memory returns the word one clock later. The sequencer forwards that word with a valid flag.

Software sets four things before a session: where the segment starts, how many words it holds, how it repeats and a repeat count. A single toggle pulse starts a session when the sequencer is idle and ends it when it is playing. The start is refused when no vector has been loaded, and it is rejected with an error status when the segment is not well formed. Passes follow each other with no gap, so a repeated segment forms one unbroken stream. The configuration is captured when a session starts, so later register writes do not disturb a running session.

Top module: `pat_player`

## Requirements
- R1: After reset no read is issued, `out_valid` is low, and `status` reads 0 (idle) when `vec_loaded` is high or 1 (no vector) when it is low. Status codes are 0 idle, 1 no vector, 2 playing, 3 done, 4 error. Code 1 is shown whenever the sequencer is not playing and `vec_loaded` is low.
- R2: A toggle pulse while `vec_loaded` is low issues no read and leaves the sequencer not playing.
- R3: A start is rejected when any of these holds: the length is zero, offset plus length exceeds `vec_words`, the mode is count with a count of zero, or the mode code is 3. A rejected start sets status 4 and issues no read.
- R4: After an accepted start, reads run one per cycle from the offset upward. Each word appears on `out_data` with `out_valid` high exactly one cycle after its read. The first read comes in the cycle after the toggle is sampled.
- R5: After the last word of the segment (offset+length-1), the next read goes back to the offset with no idle cycle, so the output stream stays continuous across passes.
- R6: Mode code 2 (once) plays the segment a single time and then shows status 3. `cfg_count` has no effect in this mode.
- R7: Mode code 1 (count) plays exactly `cfg_count` passes and then shows status 3.
- R8: Mode code 0 (loop) repeats the segment until a stop, and `cfg_count` has no effect in this mode.
- R9: A toggle pulse while playing lets the read of that cycle complete. Reads stop from the next cycle, `out_valid` drops one cycle later, and status returns to 0.
- R10: Changes to offset, length, mode or count while a session runs do not alter the word sequence of that session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_toggle | input | 1 | One-cycle pulse: start when not playing, stop when playing |
| vec_loaded | input | 1 | High when a vector is present in the pattern memory |
| vec_words | input | AW+1 | Size of the loaded vector in 256-bit words |
| cfg_offset | input | AW | First word of the segment |
| cfg_length | input | AW+1 | Segment length in words |
| cfg_mode | input | 2 | 0 loop, 1 count, 2 once, 3 invalid |
| cfg_count | input | CW | Number of passes in count mode |
| mem_rd_en | output | 1 | Pattern memory read enable |
| mem_rd_addr | output | AW | Pattern memory word address |
| mem_rd_data | input | DW | Word returned one cycle after the read |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output word |
| status | output | 3 | Sequencer status code |

## Verification
The assertions take for granted that `cmd_toggle` is a single-cycle pulse, that `vec_loaded` and `vec_words` stay steady while a session runs, and that the memory answers each read exactly one cycle later. The bench keeps to these assumptions. It pulses the toggle for one cycle from a task, changes the loaded flag only between sessions, and models the memory as a registered lookup whose word is a hash of its address. With a 12-word vector, the bench sweeps every small offset and length in once mode and a grid of offsets, lengths and counts in count mode. For each run it computes the expected word order and session length from the requirements.

// File: rtl/pat_player_pkg.sv
package pat_player_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_NOLOAD = 3'd1,
    ST_PLAY   = 3'd2,
    ST_DONE   = 3'd3,
    ST_ERR    = 3'd4
  } status_e;

  localparam logic [1:0] MD_LOOP  = 2'd0;
  localparam logic [1:0] MD_COUNT = 2'd1;
  localparam logic [1:0] MD_ONCE  = 2'd2;

  // Segment must be non-empty and lie inside the loaded vector.
  function automatic logic seg_fits(input int unsigned off,
                                    input int unsigned len,
                                    input int unsigned size);
    return (len != 0) && ((off + len) <= size);
  endfunction

  // Mode code must be known; count mode needs at least one pass.
  function automatic logic mode_fits(input logic [1:0] m, input logic cnt_zero);
    case (m)
      MD_LOOP, MD_ONCE: return 1'b1;
      MD_COUNT:         return !cnt_zero;
      default:          return 1'b0;
    endcase
  endfunction

  // Final segment address from base and length (length >= 1).
  function automatic int unsigned seg_last(input int unsigned off,
                                           input int unsigned len);
    return off + len - 1;
  endfunction

endpackage

// File: rtl/pp_cfg_check.sv
module pp_cfg_check
  import pat_player_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 16
) (
  input  logic [AW-1:0] offset,
  input  logic [AW:0]   length,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] count,
  input  logic [AW:0]   size,
  output logic          cfg_ok
);
  logic fits_w;
  logic mode_w;

  always_comb begin
    fits_w = seg_fits(32'(offset), 32'(length), 32'(size));
    mode_w = mode_fits(mode, count == '0);
    cfg_ok = fits_w && mode_w;
  end
endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen
  import pat_player_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] offset,
  input  logic [AW:0]   length,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] seg_base,
  output logic          at_last,
  output logic          final_pass
);
  logic [AW-1:0] addr_q, base_q, last_q;
  logic [CW-1:0] pass_q, passes_q;
  logic [1:0]    mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      base_q   <= '0;
      last_q   <= '0;
      pass_q   <= '0;
      passes_q <= '0;
      mode_q   <= MD_LOOP;
    end else if (load) begin
      addr_q   <= offset;
      base_q   <= offset;
      last_q   <= AW'(seg_last(32'(offset), 32'(length)));
      pass_q   <= CW'(1);
      passes_q <= count;
      mode_q   <= mode;
    end else if (adv) begin
      if (at_last) begin
        addr_q <= base_q;
        pass_q <= pass_q + CW'(1);
      end else begin
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  always_comb begin
    rd_addr    = addr_q;
    seg_base   = base_q;
    at_last    = (addr_q == last_q);
    final_pass = (mode_q == MD_ONCE) ||
                 ((mode_q == MD_COUNT) && (pass_q == passes_q));
  end
endmodule

// File: rtl/pp_out_stage.sv
module pp_out_stage #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_en;
  end

  always_comb begin
    out_valid = vld_q;
    out_data  = vld_q ? rd_data : '0;
  end
endmodule

// File: rtl/pat_player.sv
module pat_player
  import pat_player_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 256,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_toggle,
  input  logic          vec_loaded,
  input  logic [AW:0]   vec_words,
  input  logic [AW-1:0] cfg_offset,
  input  logic [AW:0]   cfg_length,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_count,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [2:0]    status
);
  status_e       st_q;
  logic          playing;
  logic          cfg_ok;
  logic          start_ok, start_bad, stop_evt, end_evt;
  logic          at_last, final_pass;
  logic [AW-1:0] seg_base;

  pp_cfg_check #(.AW(AW), .CW(CW)) u_cfg (
    .offset (cfg_offset),
    .length (cfg_length),
    .mode   (cfg_mode),
    .count  (cfg_count),
    .size   (vec_words),
    .cfg_ok (cfg_ok)
  );

  always_comb begin
    playing   = (st_q == ST_PLAY);
    start_ok  = cmd_toggle && !playing && vec_loaded && cfg_ok;
    start_bad = cmd_toggle && !playing && vec_loaded && !cfg_ok;
    stop_evt  = cmd_toggle && playing;
    end_evt   = playing && !cmd_toggle && at_last && final_pass;
    mem_rd_en = playing;
  end

  pp_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_ok),
    .adv        (playing),
    .offset     (cfg_offset),
    .length     (cfg_length),
    .mode       (cfg_mode),
    .count      (cfg_count),
    .rd_addr    (mem_rd_addr),
    .seg_base   (seg_base),
    .at_last    (at_last),
    .final_pass (final_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         st_q <= ST_IDLE;
    else if (start_ok)  st_q <= ST_PLAY;
    else if (start_bad) st_q <= ST_ERR;
    else if (stop_evt)  st_q <= ST_IDLE;
    else if (end_evt)   st_q <= ST_DONE;
  end

  pp_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (mem_rd_en),
    .rd_data   (mem_rd_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always_comb begin
    status = (!playing && !vec_loaded) ? 3'(ST_NOLOAD) : 3'(st_q);
  end
endmodule

// File: rtl/pat_player_chk.sv
module pat_player_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_toggle,
  input logic          vec_loaded,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] seg_base,
  input logic          at_last,
  input logic          end_evt,
  input logic          start_bad,
  input logic          out_valid,
  input logic [2:0]    status
);
  // R4: inside a segment the address climbs by one each cycle
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !at_last && !cmd_toggle) |=> (rd_en && rd_addr == AW'($past(rd_addr) + 1'b1)));

  // R5: after the final word of a non-final pass, reads restart at the base
  a_r5_wrap_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && at_last && !end_evt && !cmd_toggle) |=> (rd_en && rd_addr == seg_base));

  // R4: each read yields a valid word one cycle later
  a_r4_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> out_valid);

  // R9: no read, no valid word in the next cycle
  a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !out_valid);

  // R9: a stop halts reads and returns to idle
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd_toggle) |=> (!rd_en && (status == 3'd0 || status == 3'd1)));

  // R2: without a vector an idle sequencer stays idle
  a_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_loaded && !rd_en) |=> !rd_en);

  // R3: a rejected start reports an error and reads nothing
  a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (!rd_en && (status == 3'd4 || status == 3'd1)));

  // R6 / R7: the end of the final pass leads to done
  a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!rd_en && (status == 3'd3 || status == 3'd1)));
endmodule

bind pat_player pat_player_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_toggle (cmd_toggle),
  .vec_loaded (vec_loaded),
  .rd_en      (mem_rd_en),
  .rd_addr    (mem_rd_addr),
  .seg_base   (seg_base),
  .at_last    (at_last),
  .end_evt    (end_evt),
  .start_bad  (start_bad),
  .out_valid  (out_valid),
  .status     (status)
);

// File: tb/pat_player_bench.sv
module pat_player_bench;
  localparam int AW  = 4;
  localparam int DW  = 64;
  localparam int CW  = 3;
  localparam int VEC = 12;
  localparam logic [1:0] M_LOOP = 2'd0, M_COUNT = 2'd1, M_ONCE = 2'd2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_toggle = 1'b0;
  logic          vec_loaded = 1'b1;
  logic [AW:0]   vec_words = (AW+1)'(VEC);
  logic [AW-1:0] cfg_offset = '0;
  logic [AW:0]   cfg_length = '0;
  logic [1:0]    cfg_mode = M_ONCE;
  logic [CW-1:0] cfg_count = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [2:0]    status;

  pat_player #(.AW(AW), .DW(DW), .CW(CW)) u_pat_player (
    .clk(clk), .rst_n(rst_n), .cmd_toggle(cmd_toggle), .vec_loaded(vec_loaded),
    .vec_words(vec_words), .cfg_offset(cfg_offset), .cfg_length(cfg_length),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
    .out_data(out_data), .status(status));

  function automatic logic [DW-1:0] word_of(input int unsigned a);
    logic [31:0] h;
    h = 32'h9E3779B9 * (a + 7);
    return {h, ~h ^ 32'(a)};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= word_of(32'(mem_rd_addr));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Pulse the toggle; returns at the negedge after the pulse (first read cycle).
  task automatic start(input int off, input int len, input logic [1:0] md, input int cnt);
    @(negedge clk);
    cfg_offset = AW'(off);
    cfg_length = (AW+1)'(len);
    cfg_mode   = md;
    cfg_count  = CW'(cnt);
    cmd_toggle = 1'b1;
    @(negedge clk);
    cmd_toggle = 1'b0;
  endtask

  task automatic run_finite(input int off, input int len, input logic [1:0] md,
                            input int cnt, input string req);
    int total, bad, bad_i;
    total = (md == M_ONCE) ? len : len * cnt;
    bad = 0; bad_i = -1;
    start(off, len, md, cnt);
    chk(status == 3'd2, req, "status playing", status, 2);
    @(negedge clk);
    for (int i = 0; i < total; i++) begin
      if (!out_valid || out_data !== word_of(32'(off + i % len))) begin
        if (bad == 0) bad_i = i;
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, req, "stream words (first bad index as actual)", bad_i, -1);
    chk(!out_valid && status == 3'd3 && !mem_rd_en, req, "done after final word",
        {out_valid, status}, 3);
  endtask

  // Loop mode; stop toggled j cycles after the first read. Optionally rewrites cfg mid-run.
  task automatic run_loop(input int off, input int len, input int j, input int cnt,
                          input bit scramble, input string req);
    int bad, bad_k;
    bad = 0; bad_k = -1;
    start(off, len, M_LOOP, cnt);
    for (int k = 0; k <= j + 2; k++) begin
      logic exp_v;
      exp_v = (k >= 1) && (k <= j + 1);
      if (out_valid !== exp_v ||
          (exp_v && out_data !== word_of(32'(off + (k - 1) % len)))) begin
        if (bad == 0) bad_k = k;
        bad++;
      end
      if (scramble && k == 1) begin
        cfg_offset = AW'(0);
        cfg_length = (AW+1)'(1);
        cfg_mode   = M_ONCE;
      end
      cmd_toggle = (k == j);
      @(negedge clk);
    end
    cmd_toggle = 1'b0;
    chk(bad == 0, req, "loop stream and stop (first bad cycle as actual)", bad_k, -1);
    chk(status == 3'd0 && !mem_rd_en && !out_valid, "R9", "idle after stop", status, 0);
  endtask

  task automatic run_reject(input int off, input int len, input logic [1:0] md, input int cnt);
    start(off, len, md, cnt);
    chk(status == 3'd4 && !mem_rd_en, "R3", "rejected start status", status, 4);
    @(negedge clk);
    chk(!out_valid && !mem_rd_en, "R3", "no read after reject", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(status == 3'd0, "R1", "status after reset", status, 0);
    chk(!mem_rd_en && !out_valid, "R1", "no activity after reset", {mem_rd_en, out_valid}, 0);
    vec_loaded = 1'b0;
    @(negedge clk);
    chk(status == 3'd1, "R1", "status without vector", status, 1);

    // R2: start refused without vector
    start(0, 4, M_ONCE, 0);
    chk(status == 3'd1 && !mem_rd_en, "R2", "refused start", status, 1);
    repeat (2) @(negedge clk);
    chk(!mem_rd_en && !out_valid, "R2", "no reads while unloaded", out_valid, 0);
    vec_loaded = 1'b1;
    @(negedge clk);
    chk(status == 3'd0, "R2", "idle after load", status, 0);

    // R3: reject cases
    run_reject(0, 0, M_ONCE, 1);
    run_reject(10, 3, M_ONCE, 1);
    run_reject(0, 2, M_COUNT, 0);
    run_reject(0, 2, 2'd3, 1);

    // R4 / R6: once-mode sweep, count value ignored
    for (int off = 0; off < 4; off++)
      for (int len = 1; len <= 4; len++)
        run_finite(off, len, M_ONCE, (off + len) % 8, "R6");
    run_finite(8, 4, M_ONCE, 0, "R4");
    run_finite(0, 12, M_ONCE, 3, "R4");

    // R5 / R7: count-mode sweep
    for (int off = 0; off < 3; off++)
      for (int len = 1; len <= 3; len++)
        for (int cnt = 1; cnt <= 3; cnt++)
          run_finite(off * 4, len, M_COUNT, cnt, "R7");
    run_finite(9, 3, M_COUNT, 7, "R5");

    // R8 / R9 / R10: loop and stop
    run_loop(2, 3, 10, 0, 1'b0, "R8");
    run_loop(5, 1, 4, 6, 1'b0, "R8");
    run_loop(0, 12, 0, 0, 1'b0, "R9");
    run_loop(3, 4, 9, 2, 1'b1, "R10");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule